// File: doc/BRIEF.md
# Stream Operator Firing Controller

This block is the control unit of a small streaming operator. It has three input token streams (A, B, C) and three output streams (X, Y, Z). Each uses a valid/ready handshake. The operator moves through a small set of states. Every state carries two masks. The input mask lists the streams whose tokens the state needs. The output mask lists the streams the state writes.

In each cycle the current state is checked. If every required input holds a token, and every output it writes can take a new item, the operator fires in that single cycle. A firing consumes exactly the required tokens, loads the output registers and moves to the next state. If either condition fails, the operator waits, and nothing is consumed or emitted.

The behaviour of each state is set by parameters:
- the input mask;
- the output mask;
- the source of the output data;
- an optional branch on bit 0 of the A token;
- the two successor states.

The default table implements a boolean-steered selector:
- State 0 reads a control token from A. If bit 0 of that token is 1 the next state is 1; if it is 0 the next state is 2.
- State 1 reads B and sends that value on X.
- State 2 reads B and C together and sends the C value on both Y and Z. The B token is consumed and dropped.

Top module: `stream_fire_ctrl`

## Requirements
- R1: While rst is high, every input ready is low, whatever the input valids are. In the cycle after reset, all output valids are low and the state is the initial state (0).
- R2: Reads are blocking. The state does not change, and no output is loaded, until every input in the current state's input mask is valid. In state 1, a valid A token is not taken, and X stays empty while B is absent.
- R3: Input ready is high only for streams in the current state's input mask, and only in a firing cycle. In state 0, valid tokens on B and C see ready low, and no output is produced.
- R4: A state that writes an output fires only if that output register is empty, or is being drained in the same cycle. Otherwise the firing stalls and its input tokens stay unconsumed.
- R5: An output item becomes valid in the clock cycle after its firing. It holds its valid and its data unchanged while the downstream ready is low.
- R6: In state 0 the controller consumes the A token and branches on its bit 0: the value 1 selects state 1 and the value 0 selects state 2.
- R7: Default table routing. State 1 consumes B and emits that B value on X. State 2 consumes B and C in the same cycle and emits the C value on both Y and Z. Items appear on each output in firing order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Token present on input stream A |
| a_ready | output | 1 | Token on A consumed this cycle |
| a_data | input | DW | Data of stream A (bit 0 is the branch flag) |
| b_valid | input | 1 | Token present on input stream B |
| b_ready | output | 1 | Token on B consumed this cycle |
| b_data | input | DW | Data of stream B |
| c_valid | input | 1 | Token present on input stream C |
| c_ready | output | 1 | Token on C consumed this cycle |
| c_data | input | DW | Data of stream C |
| x_valid | output | 1 | Item held on output stream X |
| x_ready | input | 1 | Downstream accepts X |
| x_data | output | DW | Data of stream X |
| y_valid | output | 1 | Item held on output stream Y |
| y_ready | input | 1 | Downstream accepts Y |
| y_data | output | DW | Data of stream Y |
| z_valid | output | 1 | Item held on output stream Z |
| z_ready | input | 1 | Downstream accepts Z |
| z_data | output | DW | Data of stream Z |

## Verification
The hardest case to reach is a firing held back only by a full output register, while all of its input tokens are already present. The bench creates it in steps:
- It holds X ready low.
- It completes one A and B firing so that X fills.
- It feeds another A token with bit 0 set, so the controller reaches state 1 again.
- It then offers a B token and watches B ready stay low for several cycles while the X data holds still.

When X ready is raised, the drain and the next firing land in the same cycle. A random phase then toggles the three downstream readies under a long run of mixed branch values, and the scoreboard confirms ordering and routing.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned NPORT = 3;
  typedef logic [NPORT-1:0] port_mask_t;
  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2
  } src_sel_e;
endpackage

// File: rtl/sfc_sig_table.sv
// Per-state lookup of input mask, output mask, data source and successors.
module sfc_sig_table
  import sfc_pkg::*;
#(
  parameter int NS = 3,
  parameter int SW = 2,
  parameter logic [NS*NPORT-1:0] IN_SIG  = '0,
  parameter logic [NS*NPORT-1:0] OUT_SIG = '0,
  parameter logic [NS*2-1:0]     SRC_SEL = '0,
  parameter logic [NS-1:0]       BR_EN   = '0,
  parameter logic [NS*SW-1:0]    NXT_T   = '0,
  parameter logic [NS*SW-1:0]    NXT_F   = '0
) (
  input  logic [SW-1:0] st,
  output port_mask_t    need,
  output port_mask_t    emit,
  output src_sel_e      src,
  output logic          br,
  output logic [SW-1:0] nt,
  output logic [SW-1:0] nf
);
  always_comb begin
    need = '0;
    emit = '0;
    src  = SRC_A;
    br   = 1'b0;
    nt   = st;
    nf   = st;
    for (int s = 0; s < NS; s++) begin
      if (st == SW'(s)) begin
        need = IN_SIG[s*NPORT +: NPORT];
        emit = OUT_SIG[s*NPORT +: NPORT];
        src  = src_sel_e'(SRC_SEL[s*2 +: 2]);
        br   = BR_EN[s];
        nt   = NXT_T[s*SW +: SW];
        nf   = NXT_F[s*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/sfc_fire_rule.sv
// Firing condition: all needed inputs valid and all written outputs free.
module sfc_fire_rule
  import sfc_pkg::*;
(
  input  logic       hold,
  input  port_mask_t need,
  input  port_mask_t emit,
  input  port_mask_t in_valid,
  input  port_mask_t slot_free,
  output logic       fire,
  output port_mask_t in_ready
);
  port_mask_t in_ok;
  port_mask_t out_ok;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign in_ok[i]    = !need[i] || in_valid[i];
    assign out_ok[i]   = !emit[i] || slot_free[i];
    assign in_ready[i] = need[i] && fire;
  end

  assign fire = !hold && (&in_ok) && (&out_ok);
endmodule

// File: rtl/sfc_out_slot.sv
// One-entry registered output stage.
module sfc_out_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          drain,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data <= din;
    end
  end
endmodule

// File: rtl/stream_fire_ctrl.sv
module stream_fire_ctrl
  import sfc_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NS      = 3,
  parameter int SW      = 2,
  parameter int INIT_ST = 0,
  // Input mask per state: bit0 A, bit1 B, bit2 C
  parameter logic [NS*NPORT-1:0] IN_SIG  = 9'b110_010_001,
  // Output mask per state: bit0 X, bit1 Y, bit2 Z
  parameter logic [NS*NPORT-1:0] OUT_SIG = 9'b110_001_000,
  // Data source per state: 0 A, 1 B, 2 C
  parameter logic [NS*2-1:0]     SRC_SEL = 6'b10_01_00,
  // Branch on bit 0 of the A token
  parameter logic [NS-1:0]       BR_EN   = 3'b001,
  parameter logic [NS*SW-1:0]    NXT_T   = 6'b00_00_01,
  parameter logic [NS*SW-1:0]    NXT_F   = 6'b00_00_10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [DW-1:0] b_data,
  input  logic          c_valid,
  output logic          c_ready,
  input  logic [DW-1:0] c_data,
  output logic          x_valid,
  input  logic          x_ready,
  output logic [DW-1:0] x_data,
  output logic          y_valid,
  input  logic          y_ready,
  output logic [DW-1:0] y_data,
  output logic          z_valid,
  input  logic          z_ready,
  output logic [DW-1:0] z_data
);
  logic [SW-1:0] st_q;
  logic [SW-1:0] st_d;
  port_mask_t    need;
  port_mask_t    emit;
  src_sel_e      src;
  logic          br;
  logic [SW-1:0] nt;
  logic [SW-1:0] nf;
  logic          fire;
  port_mask_t    in_valid_v;
  port_mask_t    in_ready_v;
  port_mask_t    out_valid_v;
  port_mask_t    out_ready_v;
  port_mask_t    slot_free;
  logic [DW-1:0] out_data_v [NPORT];
  logic [DW-1:0] sel_data;

  assign in_valid_v  = {c_valid, b_valid, a_valid};
  assign out_ready_v = {z_ready, y_ready, x_ready};

  sfc_sig_table #(
    .NS(NS), .SW(SW), .IN_SIG(IN_SIG), .OUT_SIG(OUT_SIG),
    .SRC_SEL(SRC_SEL), .BR_EN(BR_EN), .NXT_T(NXT_T), .NXT_F(NXT_F)
  ) u_table (
    .st(st_q), .need(need), .emit(emit), .src(src),
    .br(br), .nt(nt), .nf(nf)
  );

  sfc_fire_rule u_rule (
    .hold(rst), .need(need), .emit(emit), .in_valid(in_valid_v),
    .slot_free(slot_free), .fire(fire), .in_ready(in_ready_v)
  );

  always_comb begin
    case (src)
      SRC_B:   sel_data = b_data;
      SRC_C:   sel_data = c_data;
      default: sel_data = a_data;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (fire) begin
      st_d = (br && !a_data[0]) ? nf : nt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SW'(INIT_ST);
    end else begin
      st_q <= st_d;
    end
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    assign slot_free[j] = !out_valid_v[j] || out_ready_v[j];
    sfc_out_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst(rst), .load(fire && emit[j]), .din(sel_data),
      .drain(out_ready_v[j]), .valid(out_valid_v[j]), .data(out_data_v[j])
    );
  end

  assign a_ready = in_ready_v[0];
  assign b_ready = in_ready_v[1];
  assign c_ready = in_ready_v[2];
  assign x_valid = out_valid_v[0];
  assign y_valid = out_valid_v[1];
  assign z_valid = out_valid_v[2];
  assign x_data  = out_data_v[0];
  assign y_data  = out_data_v[1];
  assign z_data  = out_data_v[2];
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int DW      = 8,
  parameter int SW      = 2,
  parameter int INIT_ST = 0
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    in_valid,
  input logic [2:0]    in_ready,
  input logic [2:0]    out_valid,
  input logic [2:0]    out_ready,
  input logic [3*DW-1:0] out_data,
  input logic [SW-1:0] st
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (out_valid == 3'b000) && (st == SW'(INIT_ST)));

  // R1
  reset_noready_chk: assert property (@(posedge clk)
    rst |-> (in_ready == 3'b000));

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == 3'b000);

  // R2
  st_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready == 3'b000) |=> $stable(st));

  for (genvar j = 0; j < 3; j++) begin : g_hold
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[j] && !out_ready[j]) |=>
        (out_valid[j] && $stable(out_data[j*DW +: DW])));
  end
endmodule

bind stream_fire_ctrl sfc_chk #(.DW(DW), .SW(SW), .INIT_ST(INIT_ST)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid_v), .in_ready(in_ready_v),
  .out_valid(out_valid_v), .out_ready(out_ready_v),
  .out_data({z_data, y_data, x_data}), .st(st_q)
);

// File: tb/stream_fire_ctrl_tb.sv
module stream_fire_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic a_v = 0, b_v = 0, c_v = 0;
  logic [DW-1:0] a_d = '0, b_d = '0, c_d = '0;
  logic a_r, b_r, c_r;
  logic x_v, y_v, z_v;
  logic [DW-1:0] x_d, y_d, z_d;
  logic xr = 1, yr = 1, zr = 1;
  bit rnd_en = 0;
  bit done = 0;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] qx[$];
  logic [DW-1:0] qy[$];
  logic [DW-1:0] qz[$];

  stream_fire_ctrl #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .a_valid(a_v), .a_ready(a_r), .a_data(a_d),
    .b_valid(b_v), .b_ready(b_r), .b_data(b_d),
    .c_valid(c_v), .c_ready(c_r), .c_data(c_d),
    .x_valid(x_v), .x_ready(xr), .x_data(x_d),
    .y_valid(y_v), .y_ready(yr), .y_data(y_d),
    .z_valid(z_v), .z_ready(zr), .z_data(z_d)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Offer one token on input i and wait until it is consumed.
  task automatic send(int i, logic [DW-1:0] d);
    case (i)
      0: begin a_d = d; a_v = 1; end
      1: begin b_d = d; b_v = 1; end
      default: begin c_d = d; c_v = 1; end
    endcase
    #1;
    while (!((i == 0 && a_r) || (i == 1 && b_r) || (i == 2 && c_r))) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    case (i)
      0: a_v = 0;
      1: b_v = 0;
      default: c_v = 0;
    endcase
  endtask

  // Driver: one full selector round, expected items pushed first.
  task automatic fire_sel(bit sel, logic [DW-1:0] bv, logic [DW-1:0] cv);
    if (sel) begin
      qx.push_back(bv);           // R6 sel=1 -> state 1, R7 B to X
    end else begin
      qy.push_back(cv);           // R6 sel=0 -> state 2, R7 C to Y and Z
      qz.push_back(cv);
    end
    send(0, {{(DW-1){1'b0}}, sel});
    if (sel) begin
      send(1, bv);
    end else begin
      fork
        send(1, bv);
        send(2, cv);
      join
    end
  endtask

  // Monitor: compares each transfer against the scoreboard (R7).
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst) begin
        if (x_v && xr) begin
          if (qx.size() == 0) chk(0, "R7 X unexpected", x_d, 0);
          else begin logic [DW-1:0] e; e = qx.pop_front(); chk(x_d == e, "R7 X data", x_d, e); end
        end
        if (y_v && yr) begin
          if (qy.size() == 0) chk(0, "R7 Y unexpected", y_d, 0);
          else begin logic [DW-1:0] e; e = qy.pop_front(); chk(y_d == e, "R7 Y data", y_d, e); end
        end
        if (z_v && zr) begin
          if (qz.size() == 0) chk(0, "R7 Z unexpected", z_d, 0);
          else begin logic [DW-1:0] e; e = qz.pop_front(); chk(z_d == e, "R7 Z data", z_d, e); end
        end
      end
    end
  end

  // Random downstream backpressure.
  initial begin
    forever begin
      @(negedge clk);
      if (rnd_en) {zr, yr, xr} = 3'($urandom);
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset with every input offering a token
    a_v = 1; b_v = 1; c_v = 1;
    repeat (3) @(negedge clk);
    #1;
    chk({a_r, b_r, c_r} == 3'b000, "R1 ready in reset", {a_r, b_r, c_r}, 0);
    chk({x_v, y_v, z_v} == 3'b000, "R1 outputs in reset", {x_v, y_v, z_v}, 0);
    a_v = 0; b_v = 0; c_v = 0;
    @(negedge clk);
    rst = 0;
    #1;
    chk({x_v, y_v, z_v} == 3'b000, "R1 outputs after reset", {x_v, y_v, z_v}, 0);

    // R3: B and C offered in state 0 are left alone
    @(negedge clk);
    b_v = 1; b_d = 8'hB0; c_v = 1; c_d = 8'hC0;
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(b_r == 0, "R3 b_ready in state 0", b_r, 0);
      chk(c_r == 0, "R3 c_ready in state 0", c_r, 0);
      chk({x_v, y_v, z_v} == 3'b000, "R3 no output", {x_v, y_v, z_v}, 0);
    end
    b_v = 0; c_v = 0;

    // R2: state 1 blocks without B and leaves A untouched
    send(0, 8'h01);
    a_v = 1; a_d = 8'h00;
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(a_r == 0, "R2 a_ready in state 1", a_r, 0);
      chk(x_v == 0, "R2 x empty while blocked", x_v, 0);
    end
    a_v = 0;
    qx.push_back(8'h5A);
    send(1, 8'h5A);

    // R6/R7: both branch directions
    fire_sel(1'b0, 8'h33, 8'h44);
    fire_sel(1'b1, 8'h55, 8'h66);
    repeat (3) @(negedge clk);

    // R4/R5: full X stalls the next state-1 firing
    xr = 0;
    fire_sel(1'b1, 8'h11, 8'h00);
    @(negedge clk);
    #1;
    chk(x_v == 1 && x_d == 8'h11, "R5 x holds item", x_d, 8'h11);
    send(0, 8'h01);
    b_v = 1; b_d = 8'h22;
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(b_r == 0, "R4 b stalled by full x", b_r, 0);
      chk(x_v == 1 && x_d == 8'h11, "R5 x stable", x_d, 8'h11);
    end
    qx.push_back(8'h22);
    xr = 1;
    #1;
    chk(b_r == 1, "R4 fire with x draining", b_r, 1);
    @(negedge clk);
    b_v = 0;
    repeat (3) @(negedge clk);

    // Random phase with downstream backpressure
    rnd_en = 1;
    for (int k = 0; k < 40; k++) begin
      fire_sel(1'($urandom), 8'($urandom), 8'($urandom));
    end
    rnd_en = 0;
    @(negedge clk);
    xr = 1; yr = 1; zr = 1;
    repeat (6) @(negedge clk);
    chk(qx.size() == 0, "R7 X drained", qx.size(), 0);
    chk(qy.size() == 0, "R7 Y drained", qy.size(), 0);
    chk(qz.size() == 0, "R7 Z drained", qz.size(), 0);
    finish_run();
  end
endmodule